// File: doc/BRIEF.md
# GPIO Change-Detect Interrupt Controller

This block is an eight-pin general-purpose I/O port. Each pin can be set as an input or an output. Every input pin is watched for a change of level, rising or falling. Each change is latched in a per-pin status bit. The host reads those bits to learn which pins have moved.

A single host interrupt line summarises the pending changes of the pins whose interrupt is enabled. It is gated by a global enable and shaped by a polarity setting. Registers are reached through a plain synchronous read/write port. A write takes effect on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Register map, by 3-bit address:

| Address | Register |
|---|---|
| 0 | control |
| 1 | direction |
| 2 | output level |
| 3 | pin interrupt enable |
| 4 | change status (read-only, cleared by a read) |
| others | read as 0 |

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are 0 and `irq` is 1 (active-low polarity, nothing pending). A read of each of addresses 0 to 4 returns 0.
- R2: Direction register (address 2'd1 → 3'd1): bit i = 1 makes pin i an output. `pin_oe` equals the direction register. `pin_out[i]` is the output level register bit i (address 3'd2) ANDed with direction bit i. A read of address 2 returns the value written.
- R3: A change of `pin_in[i]`, either low-to-high or high-to-low, on a pin whose direction bit is 0 sets status bit i (address 3'd4). A change applied before rising edge 1 is set by rising edge 3. A status read captured at edge 3 does not yet show it; a read captured at edge 4 does.
- R4: A change of `pin_in[i]` on a pin whose direction bit is 1 never sets status bit i.
- R5: A status bit is set by a change even when that pin's interrupt enable bit (address 3'd3) is 0.
- R6: A read of address 4 returns the status bits on `bus_rdata` in the next cycle, and clears them on the same edge.
- R7: A status bit whose change is recorded on the same edge as a status read stays set after that read. It is reported by the following read.
- R8: Control register (address 3'd0): bit 2 is the global enable and bit 0 is the polarity (1 = active high, 0 = active low). The internal request is global enable AND (any status bit ANDed with its enable bit). `irq` equals the request when polarity is 1, and its inverse when polarity is 0.
- R9: The control register stores only bits 2 and 0. A read of address 0 returns those two bits in place, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Host interrupt line |

## Verification
The bench builds the block with its default parameters: eight pins, a two-flop synchronizer, global enable at control bit 2 and polarity at bit 0. With a two-stage synchronizer, the exact three-edge latency from a pin change to its status bit is short and fixed. This lets the bench line a status read up with the very edge on which a new change lands, which exposes the read-versus-edge race. With eight pins, one test can keep outputs, enabled inputs and disabled inputs apart. Both polarities are driven, with and without the global enable.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int GPX_AW = 3;

   typedef enum logic [GPX_AW-1:0] {
      A_CTL  = 3'd0,
      A_DIR  = 3'd1,
      A_OUT  = 3'd2,
      A_IEN  = 3'd3,
      A_STAT = 3'd4
   } gpx_addr_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] edge_vec
);
   logic [NPINS-1:0] sync_lvl;
   logic [NPINS-1:0] prev_lvl;

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], pin_in[g]};
      end

      assign sync_lvl[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= '0;
      else        prev_lvl <= sync_lvl;
   end

   assign edge_vec = (sync_lvl ^ prev_lvl) & ~dir_q;
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int NPINS   = 8,
   parameter int GIE_BIT = 2,
   parameter int POL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [GPX_AW-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   input  logic [NPINS-1:0]  edge_vec,
   output logic [NPINS-1:0]  bus_rdata,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  out_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  stat_q,
   output logic              ctl_gie,
   output logic              ctl_pol,
   output logic              rd_stat
);
   logic [NPINS-1:0] rd_mux;
   logic [NPINS-1:0] ctl_view;

   assign rd_stat = bus_rd && (gpx_addr_e'(bus_addr) == A_STAT);

   always_comb begin
      ctl_view          = '0;
      ctl_view[GIE_BIT] = ctl_gie;
      ctl_view[POL_BIT] = ctl_pol;
   end

   always_comb begin
      case (gpx_addr_e'(bus_addr))
         A_CTL:   rd_mux = ctl_view;
         A_DIR:   rd_mux = dir_q;
         A_OUT:   rd_mux = out_q;
         A_IEN:   rd_mux = ien_q;
         A_STAT:  rd_mux = stat_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         out_q   <= '0;
         ien_q   <= '0;
         ctl_gie <= 1'b0;
         ctl_pol <= 1'b0;
      end else if (bus_wr) begin
         case (gpx_addr_e'(bus_addr))
            A_CTL: begin
               ctl_gie <= bus_wdata[GIE_BIT];
               ctl_pol <= bus_wdata[POL_BIT];
            end
            A_DIR:   dir_q <= bus_wdata;
            A_OUT:   out_q <= bus_wdata;
            A_IEN:   ien_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (rd_stat ? '0 : stat_q) | edge_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
   parameter int NPINS = 8
) (
   input  logic             ctl_gie,
   input  logic             ctl_pol,
   input  logic [NPINS-1:0] stat_q,
   input  logic [NPINS-1:0] ien_q,
   output logic             irq
);
   logic req;

   assign req = ctl_gie && |(stat_q & ien_q);
   assign irq = ctl_pol ? req : ~req;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
   import gpx_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GIE_BIT     = 2,
   parameter int POL_BIT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [GPX_AW-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GIE_BIT >= NPINS || POL_BIT >= NPINS || GIE_BIT == POL_BIT) begin : g_bad_ctl
      $error("control bit positions must be distinct and inside the data width");
   end

   logic [NPINS-1:0] edge_vec;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] out_q;
   logic [NPINS-1:0] ien_q;
   logic [NPINS-1:0] stat_q;
   logic             ctl_gie;
   logic             ctl_pol;
   logic             rd_stat;

   gpx_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .dir_q    (dir_q),
      .edge_vec (edge_vec)
   );

   gpx_regs #(.NPINS(NPINS), .GIE_BIT(GIE_BIT), .POL_BIT(POL_BIT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .edge_vec  (edge_vec),
      .bus_rdata (bus_rdata),
      .dir_q     (dir_q),
      .out_q     (out_q),
      .ien_q     (ien_q),
      .stat_q    (stat_q),
      .ctl_gie   (ctl_gie),
      .ctl_pol   (ctl_pol),
      .rd_stat   (rd_stat)
   );

   gpx_irq #(.NPINS(NPINS)) u_irq (
      .ctl_gie (ctl_gie),
      .ctl_pol (ctl_pol),
      .stat_q  (stat_q),
      .ien_q   (ien_q),
      .irq     (irq)
   );

   assign pin_oe  = dir_q;
   assign pin_out = out_q & dir_q;
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] bus_rdata,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic             irq,
   input logic [NPINS-1:0] stat_q,
   input logic [NPINS-1:0] edge_vec,
   input logic             ctl_gie,
   input logic             ctl_pol,
   input logic             rd_stat
);
   // R2: a pin that is not driven never shows a high output
   p_no_float_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   // R3: a status bit only appears where a change was detected
   p_new_bit_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(edge_vec)) == '0));

   // R6: status read returns the bits held at the read edge
   p_read_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> (bus_rdata == $past(stat_q)));

   // R6: without a status read, no pending bit is dropped
   p_hold_until_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R7: a change coinciding with a read survives it
   p_edge_survives_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && (edge_vec != '0)) |=> ((stat_q & $past(edge_vec)) == $past(edge_vec)));

   // R8: with the global enable off the line sits at its inactive level
   p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_gie |-> (irq == !ctl_pol));
endmodule

bind gpio_chg_irq gpx_chk #(.NPINS(NPINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .stat_q    (stat_q),
   .edge_vec  (edge_vec),
   .ctl_gie   (ctl_gie),
   .ctl_pol   (ctl_pol),
   .rd_stat   (rd_stat)
);

// File: tb/gpio_chg_irq_tb.sv
module gpio_chg_irq_tb;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out;
   logic [N-1:0] pin_oe;
   logic         irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [N-1:0] val;
      string        tag;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   gpio_chg_irq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // all driver tasks start and end at a falling edge
   task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, input logic [N-1:0] e, input string tag);
      exp_t it;
      it.val = e; it.tag = tag;
      exp_q.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic flip_pin(input int i);
      pin_in[i] = ~pin_in[i];
      repeat (4) @(negedge clk);
   endtask

   // monitor: each read strobe seen at an edge yields one response to compare
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            #2;
            if (exp_q.size() == 0) begin
               n_checks++; n_fail++;
               $display("FAIL scoreboard: unexpected read data 0x%0h", bus_rdata);
            end else begin
               exp_t it;
               it = exp_q.pop_front();
               check(it.tag, 32'(bus_rdata), 32'(it.val));
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pin_out", 32'(pin_out), 0);
      check("R1 pin_oe", 32'(pin_oe), 0);
      check("R1 irq", 32'(irq), 1);
      rd_reg(3'd0, 8'h00, "R1 ctl");
      rd_reg(3'd1, 8'h00, "R1 dir");
      rd_reg(3'd2, 8'h00, "R1 out");
      rd_reg(3'd3, 8'h00, "R1 ien");
      rd_reg(3'd4, 8'h00, "R1 stat");

      // R9 control storage
      wr_reg(3'd0, 8'hFA);
      rd_reg(3'd0, 8'h00, "R9 ctl unused bits");
      wr_reg(3'd0, 8'hFF);
      rd_reg(3'd0, 8'h05, "R9 ctl kept bits");
      check("R8 active-high idle", 32'(irq), 0);
      wr_reg(3'd0, 8'h00);
      check("R8 active-low idle", 32'(irq), 1);

      // R2 direction and output
      wr_reg(3'd1, 8'h0F);
      wr_reg(3'd2, 8'h3C);
      check("R2 pin_oe", 32'(pin_oe), 32'h0F);
      check("R2 pin_out", 32'(pin_out), 32'h0C);
      rd_reg(3'd2, 8'h3C, "R2 out readback");

      // R4 output pin changes ignored
      flip_pin(1);
      rd_reg(3'd4, 8'h00, "R4 output pin");

      // R3 / R5 both edges, enable off
      flip_pin(4);
      rd_reg(3'd4, 8'h10, "R3 R5 rising");
      rd_reg(3'd4, 8'h00, "R6 cleared");
      flip_pin(4);
      rd_reg(3'd4, 8'h10, "R3 falling");

      // R8 active low with enable
      wr_reg(3'd3, 8'h20);
      wr_reg(3'd0, 8'h04);
      flip_pin(6);
      check("R8 disabled pin no irq", 32'(irq), 1);
      flip_pin(5);
      check("R8 active low asserted", 32'(irq), 0);
      rd_reg(3'd4, 8'h60, "R6 stat two pins");
      check("R8 irq released after read", 32'(irq), 1);

      // R8 active high, then global enable off
      wr_reg(3'd0, 8'h05);
      check("R8 active-high idle", 32'(irq), 0);
      flip_pin(5);
      check("R8 active high asserted", 32'(irq), 1);
      wr_reg(3'd0, 8'h01);
      check("R8 global off", 32'(irq), 0);
      rd_reg(3'd4, 8'h20, "R6 pending kept");

      // R7 / R3 change lands on the read edge
      flip_pin(6);
      pin_in[7] = ~pin_in[7];
      @(negedge clk);
      @(negedge clk);
      rd_reg(3'd4, 8'h40, "R7 read on landing edge");
      rd_reg(3'd4, 8'h80, "R7 R3 kept after read");
      rd_reg(3'd4, 8'h00, "R6 empty");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule